// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the management registers of a 10/100 Ethernet PHY together with the MAC-side command port that reaches them. The host programs an address word that selects a PHY and a register, loads a transmit data word, and issues commands that write the selected register, read it into a receive data word, or keep the link-fail flag tracking the link input. Every command completes in the clock cycle it is issued. Serial management signalling, clock division and PHY analog behaviour are not part of the block.

The bank has sixteen 16-bit registers, and each has a fixed power-on value. The capability register and the two identifier registers cannot be written. Writing the control register with its reset bit set reloads every register instead of storing the word. The link input drives the link bit of the status register and the partner-ability register. Only one PHY address answers. A read aimed at any other address returns all ones.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, register 0 reads 0x1000 (auto-negotiation enable, bit 12), register 1 reads 0x7868 (100FD bit 14, 100HD bit 13, 10FD bit 12, 10HD bit 11, preamble suppression bit 6, negotiation complete bit 5, negotiation ability bit 3, link bit 2 clear), register 4 reads 0x01E1, all other registers read 0, and rx_data_o and link_fail_o are 0.
- R2: The address word carries the register index in bits 12:8 and the PHY address in bits 4:0. The command word uses bit 2 for write, bit 1 for read-status and bit 0 for scan. A write command stores the held transmit data into the selected register. A read-status command places the selected register, as it stood before that clock edge, on rx_data_o after the same edge.
- R3: Loading the transmit data word while the PHY address is 1 also writes that value into the selected register at the same clock edge.
- R4: When the PHY address is not 1, a read-status command returns 0xFFFF and no write reaches the bank.
- R5: Registers 2 and 3 always read 0x2000 and 0x5C90. Writes to registers 1, 2 and 3 have no effect.
- R6: A write to register 0 with bit 15 set returns every register to its R1 value and does not store the word. A write with bit 15 clear stores the word as given.
- R7: One clock edge after the link input rises, register 1 bit 2 is set and register 5 gains bits 0x01E1. One edge after it falls, bit 2 is clear and register 5 is ANDed with 0x01FF.
- R8: A soft reset applies the live link state, so with the link up, register 1 reads 0x786C and register 5 reads 0x01E1 immediately afterwards.
- R9: A read-status command loads link_fail_o with the inverse of the link input.
- R10: While the last command word had bit 0 set, link_fail_o follows the inverse of the link input with one edge of delay. After a command with bit 0 clear, it holds.
- R11: Register indices 16 to 31 ignore writes and read as 0x0000.
- R12: Registers 4 to 15 store all 16 bits of a written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Load the address word |
| addr_i | input | 16 | Address word: register index 12:8, PHY address 4:0 |
| txd_we_i | input | 1 | Load the transmit data word |
| txd_i | input | 16 | Transmit data word |
| cmd_we_i | input | 1 | Issue a command |
| cmd_i | input | 3 | Command: write bit 2, read-status bit 1, scan bit 0 |
| link_up_i | input | 1 | Link state from the line side |
| rx_data_o | output | 16 | Result of the last read-status command |
| link_fail_o | output | 1 | Captured inverse of the link state |

## Verification
The bench builds the block with its default parameters: sixteen registers behind a 5-bit index field, and a 5-bit PHY address that answers only at 1. Because the index field is wider than the bank, random addresses reach indices 16 to 31. The PHY address field leaves 31 addresses that do not answer, so foreign reads and dropped writes are exercised. Random writes to register 0 also trigger soft resets between link toggles, which checks how the defaults, the host writes and the partner-ability mask combine.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int MII_DW       = 16;
  localparam int HOST_AW      = 16;
  localparam int CMD_W        = 3;
  localparam int CMD_WRITE    = 2;
  localparam int CMD_READ     = 1;
  localparam int CMD_SCAN     = 0;
  localparam int ADDR_REG_LSB = 8;
  localparam int ADDR_PHY_LSB = 0;

  localparam int CTRL_RST     = 15;
  localparam int CTRL_ANEN    = 12;
  localparam int STAT_LINK    = 2;
  localparam int STAT_ANABL   = 3;
  localparam int STAT_ANDONE  = 5;
  localparam int STAT_PRESUP  = 6;
  localparam int STAT_10HD    = 11;
  localparam int STAT_10FD    = 12;
  localparam int STAT_100HD   = 13;
  localparam int STAT_100FD   = 14;

  localparam int IDX_CTRL     = 0;
  localparam int IDX_STAT     = 1;
  localparam int IDX_ID_HI    = 2;
  localparam int IDX_ID_LO    = 3;
  localparam int IDX_ADV      = 4;
  localparam int IDX_PARTNER  = 5;

  localparam logic [MII_DW-1:0] ABIL_SET  = 16'h01E1;
  localparam logic [MII_DW-1:0] DOWN_KEEP = 16'h01FF;

  function automatic logic [MII_DW-1:0] stat_caps();
    logic [MII_DW-1:0] v;
    v = '0;
    v[STAT_100FD]  = 1'b1;
    v[STAT_100HD]  = 1'b1;
    v[STAT_10FD]   = 1'b1;
    v[STAT_10HD]   = 1'b1;
    v[STAT_PRESUP] = 1'b1;
    v[STAT_ANDONE] = 1'b1;
    v[STAT_ANABL]  = 1'b1;
    return v;
  endfunction

  function automatic logic [MII_DW-1:0] reg_default(input int idx,
                                                    input logic [MII_DW-1:0] id_hi,
                                                    input logic [MII_DW-1:0] id_lo);
    logic [MII_DW-1:0] v;
    v = '0;
    case (idx)
      IDX_CTRL:  v[CTRL_ANEN] = 1'b1;
      IDX_STAT:  v = stat_caps();
      IDX_ID_HI: v = id_hi;
      IDX_ID_LO: v = id_lo;
      IDX_ADV:   v = ABIL_SET;
      default:   v = '0;
    endcase
    return v;
  endfunction

  function automatic logic is_read_only(input int idx);
    return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
  endfunction

  function automatic logic [MII_DW-1:0] link_effect(input int idx,
                                                    input logic [MII_DW-1:0] v,
                                                    input logic up);
    logic [MII_DW-1:0] r;
    r = v;
    if (idx == IDX_STAT) r[STAT_LINK] = up;
    else if (idx == IDX_PARTNER) r = up ? (v | ABIL_SET) : (v & DOWN_KEEP);
    return r;
  endfunction
endpackage

// File: rtl/phy_mgmt_host_if.sv
module phy_mgmt_host_if
  import phy_mgmt_pkg::*;
#(
  parameter int REG_IDX_W  = 5,
  parameter int PHY_ADDR_W = 5,
  parameter int PHY_ADDR   = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  addr_we_i,
  input  logic [HOST_AW-1:0]    addr_i,
  input  logic                  txd_we_i,
  input  logic [MII_DW-1:0]     txd_i,
  input  logic                  cmd_we_i,
  input  logic [CMD_W-1:0]      cmd_i,
  output logic                  bank_we_o,
  output logic [REG_IDX_W-1:0]  bank_idx_o,
  output logic [MII_DW-1:0]     bank_wdata_o,
  output logic                  rd_req_o,
  output logic                  rd_foreign_o,
  output logic                  scan_o,
  output logic [PHY_ADDR_W-1:0] phy_o
);
  localparam logic [HOST_AW-1:0] REG_FIELD =
    HOST_AW'(((1 << REG_IDX_W) - 1) << ADDR_REG_LSB);
  localparam logic [HOST_AW-1:0] PHY_FIELD =
    HOST_AW'(((1 << PHY_ADDR_W) - 1) << ADDR_PHY_LSB);

  logic [REG_IDX_W-1:0]  reg_idx_q;
  logic [PHY_ADDR_W-1:0] phy_q;
  logic [MII_DW-1:0]     txd_q;
  logic                  scan_q;
  logic                  phy_match;
  logic                  unused_addr_bits;

  assign unused_addr_bits = ^(addr_i & ~(REG_FIELD | PHY_FIELD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_idx_q <= '0;
      phy_q     <= '0;
      txd_q     <= '0;
      scan_q    <= 1'b0;
    end else begin
      if (addr_we_i) begin
        reg_idx_q <= addr_i[ADDR_REG_LSB +: REG_IDX_W];
        phy_q     <= addr_i[ADDR_PHY_LSB +: PHY_ADDR_W];
      end
      if (txd_we_i) txd_q <= txd_i;
      if (cmd_we_i) scan_q <= cmd_i[CMD_SCAN];
    end
  end

  assign phy_match    = (phy_q == PHY_ADDR_W'(PHY_ADDR));
  // a fresh data word takes precedence over the held one
  assign bank_wdata_o = txd_we_i ? txd_i : txd_q;
  assign bank_we_o    = phy_match && (txd_we_i || (cmd_we_i && cmd_i[CMD_WRITE]));
  assign bank_idx_o   = reg_idx_q;
  assign rd_req_o     = cmd_we_i && cmd_i[CMD_READ];
  assign rd_foreign_o = !phy_match;
  assign scan_o       = scan_q;
  assign phy_o        = phy_q;
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
#(
  parameter int              NUM_REGS  = 16,
  parameter int              REG_IDX_W = 5,
  parameter logic [MII_DW-1:0] ID_HI   = 16'h2000,
  parameter logic [MII_DW-1:0] ID_LO   = 16'h5C90
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [REG_IDX_W-1:0]              idx_i,
  input  logic [MII_DW-1:0]                 wdata_i,
  input  logic                              link_up_i,
  output logic [MII_DW-1:0]                 rdata_o,
  output logic [NUM_REGS-1:0][MII_DW-1:0]   regs_o
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                            link_q;
  logic                            link_chg;
  logic                            soft_rst;
  logic                            in_range;
  logic [NUM_REGS-1:0][MII_DW-1:0] q;

  assign link_chg = link_up_i ^ link_q;
  assign soft_rst = we_i && (idx_i == REG_IDX_W'(IDX_CTRL)) && wdata_i[CTRL_RST];
  assign in_range = ({1'b0, idx_i} < (REG_IDX_W + 1)'(NUM_REGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= 1'b0;
    else         link_q <= link_up_i;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [MII_DW-1:0] base;
    logic [MII_DW-1:0] nxt;
    logic              hit;

    assign hit = we_i && (idx_i == REG_IDX_W'(i)) && !is_read_only(i);

    always_comb begin
      if (soft_rst)  base = reg_default(i, ID_HI, ID_LO);
      else if (hit)  base = wdata_i;
      else           base = q[i];
      // link effect lands on top of the host update in the same edge
      if (soft_rst || link_chg) nxt = link_effect(i, base, link_up_i);
      else                      nxt = base;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= reg_default(i, ID_HI, ID_LO);
      else         q[i] <= nxt;
    end
  end

  assign rdata_o = in_range ? q[idx_i[SEL_W-1:0]] : '0;
  assign regs_o  = q;
endmodule

// File: rtl/phy_mgmt_status.sv
module phy_mgmt_status
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              rd_foreign_i,
  input  logic [MII_DW-1:0] rd_data_i,
  input  logic              link_up_i,
  input  logic              scan_i,
  output logic [MII_DW-1:0] rx_data_o,
  output logic              link_fail_o
);
  logic [MII_DW-1:0] rx_q;
  logic              fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      fail_q <= 1'b0;
    end else begin
      if (rd_req_i) rx_q <= rd_foreign_i ? '1 : rd_data_i;
      if (rd_req_i || scan_i) fail_q <= !link_up_i;
    end
  end

  assign rx_data_o   = rx_q;
  assign link_fail_o = fail_q;
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int                NUM_REGS   = 16,
  parameter int                REG_IDX_W  = 5,
  parameter int                PHY_ADDR_W = 5,
  parameter int                PHY_ADDR   = 1,
  parameter logic [MII_DW-1:0] ID_HI      = 16'h2000,
  parameter logic [MII_DW-1:0] ID_LO      = 16'h5C90
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic               txd_we_i,
  input  logic [MII_DW-1:0]  txd_i,
  input  logic               cmd_we_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               link_up_i,
  output logic [MII_DW-1:0]  rx_data_o,
  output logic               link_fail_o
);
  logic                            bank_we;
  logic [REG_IDX_W-1:0]            bank_idx;
  logic [MII_DW-1:0]               bank_wdata;
  logic [MII_DW-1:0]               bank_rdata;
  logic [NUM_REGS-1:0][MII_DW-1:0] bank_regs;
  logic                            rd_req;
  logic                            rd_foreign;
  logic                            scan;
  logic [PHY_ADDR_W-1:0]           cur_phy;

  phy_mgmt_host_if #(
    .REG_IDX_W (REG_IDX_W),
    .PHY_ADDR_W(PHY_ADDR_W),
    .PHY_ADDR  (PHY_ADDR)
  ) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_we_i   (addr_we_i),
    .addr_i      (addr_i),
    .txd_we_i    (txd_we_i),
    .txd_i       (txd_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_i       (cmd_i),
    .bank_we_o   (bank_we),
    .bank_idx_o  (bank_idx),
    .bank_wdata_o(bank_wdata),
    .rd_req_o    (rd_req),
    .rd_foreign_o(rd_foreign),
    .scan_o      (scan),
    .phy_o       (cur_phy)
  );

  phy_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .REG_IDX_W(REG_IDX_W),
    .ID_HI    (ID_HI),
    .ID_LO    (ID_LO)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bank_we),
    .idx_i    (bank_idx),
    .wdata_i  (bank_wdata),
    .link_up_i(link_up_i),
    .rdata_o  (bank_rdata),
    .regs_o   (bank_regs)
  );

  phy_mgmt_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req),
    .rd_foreign_i(rd_foreign),
    .rd_data_i   (bank_rdata),
    .link_up_i   (link_up_i),
    .scan_i      (scan),
    .rx_data_o   (rx_data_o),
    .link_fail_o (link_fail_o)
  );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker
  import phy_mgmt_pkg::*;
#(
  parameter int                NUM_REGS   = 16,
  parameter int                REG_IDX_W  = 5,
  parameter int                PHY_ADDR_W = 5,
  parameter int                PHY_ADDR   = 1,
  parameter logic [MII_DW-1:0] ID_HI      = 16'h2000,
  parameter logic [MII_DW-1:0] ID_LO      = 16'h5C90
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            link_up_i,
  input logic                            cmd_we_i,
  input logic [CMD_W-1:0]                cmd_i,
  input logic [MII_DW-1:0]               rx_data_o,
  input logic                            link_fail_o,
  input logic [PHY_ADDR_W-1:0]           phy_i,
  input logic                            scan_i,
  input logic                            bank_we_i,
  input logic [REG_IDX_W-1:0]            bank_idx_i,
  input logic [MII_DW-1:0]               bank_wdata_i,
  input logic [NUM_REGS-1:0][MII_DW-1:0] regs_i
);
  assert_ids_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_i[IDX_ID_HI] == ID_HI) && (regs_i[IDX_ID_LO] == ID_LO));

  assert_caps_fixed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_i[IDX_STAT] & ~(MII_DW'(1) << STAT_LINK)) == stat_caps());

  assert_link_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_i) |=> regs_i[IDX_STAT][STAT_LINK]);

  assert_link_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_up_i) |=> (!regs_i[IDX_STAT][STAT_LINK] &&
                          ((regs_i[IDX_PARTNER] & ~DOWN_KEEP) == '0)));

  assert_foreign_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[CMD_READ] && (phy_i != PHY_ADDR_W'(PHY_ADDR)))
      |=> (rx_data_o == '1));

  assert_soft_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_i && (bank_idx_i == '0) && bank_wdata_i[CTRL_RST])
      |=> ((regs_i[IDX_CTRL] == (MII_DW'(1) << CTRL_ANEN)) &&
           (regs_i[IDX_ADV] == ABIL_SET)));

  assert_scan_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_i |=> (link_fail_o == !$past(link_up_i)));
endmodule

bind phy_mgmt_regfile phy_mgmt_checker #(
  .NUM_REGS  (NUM_REGS),
  .REG_IDX_W (REG_IDX_W),
  .PHY_ADDR_W(PHY_ADDR_W),
  .PHY_ADDR  (PHY_ADDR),
  .ID_HI     (ID_HI),
  .ID_LO     (ID_LO)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .link_up_i   (link_up_i),
  .cmd_we_i    (cmd_we_i),
  .cmd_i       (cmd_i),
  .rx_data_o   (rx_data_o),
  .link_fail_o (link_fail_o),
  .phy_i       (cur_phy),
  .scan_i      (scan),
  .bank_we_i   (bank_we),
  .bank_idx_i  (bank_idx),
  .bank_wdata_i(bank_wdata),
  .regs_i      (bank_regs)
);

// File: tb/phy_mgmt_regfile_test.sv
module phy_mgmt_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        txd_we_i = 1'b0;
  logic [15:0] txd_i = '0;
  logic        cmd_we_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic        link_up_i = 1'b0;
  logic [15:0] rx_data_o;
  logic        link_fail_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] m [16];
  logic        link_m = 1'b0;
  logic        scan_m = 1'b0;
  logic [4:0]  phy_m = '0;
  logic [4:0]  idx_m = '0;
  logic [15:0] txd_m = '0;
  logic [15:0] exp_rx = '0;
  logic        exp_fail = 1'b0;

  always #10 clk_i = ~clk_i;

  phy_mgmt_regfile uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_we_i(addr_we_i), .addr_i(addr_i),
    .txd_we_i(txd_we_i), .txd_i(txd_i),
    .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
    .link_up_i(link_up_i),
    .rx_data_o(rx_data_o), .link_fail_o(link_fail_o)
  );

  function automatic logic [15:0] dflt(input int i);
    case (i)
      0: return 16'h1000;
      1: return 16'h7868;
      2: return 16'h2000;
      3: return 16'h5C90;
      4: return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic m_link(input logic up);
    m[1][2] = up;
    m[5] = up ? (m[5] | 16'h01E1) : (m[5] & 16'h01FF);
  endtask

  task automatic m_write(input logic [4:0] i, input logic [15:0] d);
    if (i >= 16) return;
    if (i == 0 && d[15]) begin
      for (int k = 0; k < 16; k++) m[k] = dflt(k);
      m_link(link_m);
    end else if (i < 1 || i > 3) m[i] = d;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op_addr(input logic [4:0] phy, input logic [4:0] idx);
    addr_we_i = 1'b1;
    addr_i = {3'b101, idx, 3'b110, phy};
    @(negedge clk_i);
    addr_we_i = 1'b0;
    phy_m = phy;
    idx_m = idx;
    if (scan_m) exp_fail = !link_m;
  endtask

  task automatic op_txd(input logic [15:0] d);
    txd_we_i = 1'b1;
    txd_i = d;
    @(negedge clk_i);
    txd_we_i = 1'b0;
    txd_m = d;
    if (phy_m == 5'd1) m_write(idx_m, d);
    if (scan_m) exp_fail = !link_m;
  endtask

  task automatic op_cmd(input logic [2:0] c);
    cmd_we_i = 1'b1;
    cmd_i = c;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    if (c[1]) exp_rx = (phy_m != 5'd1) ? 16'hFFFF : ((idx_m < 16) ? m[idx_m[3:0]] : 16'h0000);
    if (c[1] || scan_m) exp_fail = !link_m;
    if (c[2] && phy_m == 5'd1) m_write(idx_m, txd_m);
    scan_m = c[0];
  endtask

  task automatic op_link(input logic up);
    link_up_i = up;
    @(negedge clk_i);
    if (up != link_m) begin
      link_m = up;
      m_link(up);
    end
    if (scan_m) exp_fail = !link_m;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] idx, input logic [15:0] exp);
    op_addr(5'd1, idx);
    op_cmd(3'b010);
    chk(req, rx_data_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) m[k] = dflt(k);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 rx reset", rx_data_o, 16'h0000);
    chk("R1 fail reset", {15'd0, link_fail_o}, 16'h0000);
    for (int k = 0; k < 16; k++) rd_chk("R1 default", 5'(k), dflt(k));

    // R11 out-of-range index
    rd_chk("R11 read idx20", 5'd20, 16'h0000);
    op_addr(5'd1, 5'd16); op_txd(16'h8000);
    rd_chk("R11 idx16 write dropped", 5'd0, 16'h1000);

    // R2 write via command with held data
    op_addr(5'd1, 5'd7); op_addr(5'd3, 5'd7);
    op_txd(16'hA55A);
    op_addr(5'd1, 5'd7); op_cmd(3'b100);
    rd_chk("R2 command write", 5'd7, 16'hA55A);

    // R3 immediate write on data load
    op_addr(5'd1, 5'd9); op_txd(16'h1234);
    rd_chk("R3 data load writes", 5'd9, 16'h1234);

    // R4 foreign PHY
    op_addr(5'd2, 5'd9); op_txd(16'hBEEF); op_cmd(3'b110);
    chk("R4 foreign read", rx_data_o, 16'hFFFF);
    rd_chk("R4 foreign write dropped", 5'd9, 16'h1234);

    // R5 read-only registers
    for (int k = 1; k < 4; k++) begin
      op_addr(5'd1, 5'(k)); op_txd(16'h0F0F);
      rd_chk("R5 read-only", 5'(k), dflt(k));
    end

    // R12 full width storage
    op_addr(5'd1, 5'd15); op_txd(16'hFFFF);
    rd_chk("R12 full word", 5'd15, 16'hFFFF);
    op_addr(5'd1, 5'd4); op_txd(16'h8001);
    rd_chk("R12 adv reg", 5'd4, 16'h8001);

    // R6 store then soft reset
    op_addr(5'd1, 5'd0); op_txd(16'h0140);
    rd_chk("R6 plain store", 5'd0, 16'h0140);
    op_addr(5'd1, 5'd0); op_txd(16'h8000);
    rd_chk("R6 soft reset ctrl", 5'd0, 16'h1000);
    rd_chk("R6 soft reset adv", 5'd4, 16'h01E1);
    rd_chk("R6 soft reset reg15", 5'd15, 16'h0000);

    // R7 link up/down
    op_addr(5'd1, 5'd5); op_txd(16'hFE00);
    op_link(1'b1);
    rd_chk("R7 link up status", 5'd1, 16'h786C);
    rd_chk("R7 link up partner", 5'd5, 16'hFFE1);
    op_link(1'b0);
    rd_chk("R7 link down status", 5'd1, 16'h7868);
    rd_chk("R7 link down partner", 5'd5, 16'h01E1);

    // R8 soft reset with live link
    op_link(1'b1);
    op_addr(5'd1, 5'd5); op_txd(16'h0002);
    op_addr(5'd1, 5'd0); op_txd(16'h8000);
    rd_chk("R8 status after soft reset", 5'd1, 16'h786C);
    rd_chk("R8 partner after soft reset", 5'd5, 16'h01E1);

    // R9 read captures link fail
    op_link(1'b0);
    op_cmd(3'b010);
    chk("R9 fail on read", {15'd0, link_fail_o}, 16'h0001);
    op_link(1'b1);
    chk("R9 holds without read", {15'd0, link_fail_o}, 16'h0001);
    op_cmd(3'b010);
    chk("R9 clear on read", {15'd0, link_fail_o}, 16'h0000);

    // R10 scan tracking
    op_cmd(3'b001);
    op_link(1'b0);
    chk("R10 scan tracks down", {15'd0, link_fail_o}, 16'h0001);
    op_link(1'b1);
    chk("R10 scan tracks up", {15'd0, link_fail_o}, 16'h0000);
    op_cmd(3'b000);
    op_link(1'b0);
    chk("R10 scan off holds", {15'd0, link_fail_o}, 16'h0000);

    // random mix, R2 R3 R4 R6 R7 R9 R10 R11 R12 against model
    for (int n = 0; n < 600; n++) begin
      int unsigned sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: op_addr(($urandom_range(0, 4) == 0) ? 5'($urandom) : 5'd1,
                      5'($urandom_range(0, 21)));
        2, 3: op_txd(($urandom_range(0, 3) == 0) ? (16'($urandom) | 16'h8000)
                                                  : (16'($urandom) & 16'h7FFF));
        4, 5: op_cmd(3'($urandom));
        6:    op_link(1'($urandom));
        default: op_cmd({1'b0, 1'b1, 1'($urandom)});
      endcase
      chk("R2 random rx", rx_data_o, exp_rx);
      chk("R10 random fail", {15'd0, link_fail_o}, {15'd0, exp_fail});
    end
    for (int k = 0; k < 16; k++) rd_chk("R12 final sweep", 5'(k), m[k]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule